// File: doc/BRIEF.md
# DMA Page-Map Translator with Lane Packing

This block sits between an 18-bit byte-addressed peripheral bus and a memory built from 36-bit words. A DMA byte address is turned into a word index by dropping its two low bits, so four bus bytes share one memory word. The upper part of that index selects an entry in a small page map and the lower part is the offset inside the page. The map entry supplies the physical page number. The host loads and reads map entries through a plain indexed port. The memory is an internal word array, with its own host port for loading and inspection.

A transfer engine is started with a bus address, a byte count, a width (byte or 16-bit) and a direction. It handles one unit per clock. Going toward memory, it merges the device data into the addressed lane of the memory word. Going from memory, it extracts the lane and presents it on a read-data port. If a translation fails, or the translated word lies beyond the memory, the engine stops. It reports the bytes not moved and raises a sticky adapter timeout flag. A complete transfer reports zero.

Top module: `dma_lane_mapper`

## Requirements
- R1: A bus address A maps to word index A[17:2]. The page number is the index shifted right by OFF_W and the offset is the low OFF_W bits of the index. The physical word address is {entry page number, offset}.
- R2: A host map write stores bit 15 of the data as the valid flag and bits PPN_W-1:0 as the page number, where PPN_W = PA_W - OFF_W. A read returns those two fields at the same positions with every other bit zero. A write is visible on the read port on the next cycle.
- R3: Translation fails when bus address bit 17 is set, when the page number is not below MAP_DEPTH, or when the selected entry is not valid.
- R4: A byte read takes lane A[1:0] = 0, 1, 2, 3 from word bits 25:18, 33:26, 7:0 and 15:8 respectively, zero-extended to 16 bits.
- R5: A byte write replaces only the 8 bits of its lane (same positions as R4) with device data bits 7:0.
- R6: In word mode the start address and the count have bit 0 forced to zero. A[1] = 1 selects word bits 15:0 and A[1] = 0 selects bits 33:18.
- R7: A word write replaces only the selected 16-bit field. All other bits of the memory word are kept, including bits 35:34 and 17:16.
- R8: When a unit fails translation, or its physical address is not below MEM_WORDS, the transfer ends at once with the remaining count as the residual. Nothing is written for that unit, and the adapter timeout flag is set and stays set until reset.
- R9: A transfer that moves every unit ends with residual 0. A count of zero ends on the first engine cycle with residual 0.
- R10: The engine handles one unit per clock starting on the edge after the start edge. Read data and its valid flag appear after the edge that handles the unit. Done is a one-cycle pulse after the edge following the last unit, and busy is low while done is high.
- R11: Reset clears every map entry to zero and clears the timeout flag, done, busy and read-valid.
- R12: A transfer from memory leaves every memory word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_idx | input | MAP_IW | Map entry index for host access |
| map_we | input | 1 | Host map write strobe |
| map_wdata | input | 18 | Host map write data (valid at bit 15, page number at low bits) |
| map_rdata | output | 18 | Masked map entry at map_idx |
| mem_idx | input | MEM_AW | Host memory word index |
| mem_we | input | 1 | Host memory write strobe (engine writes take priority) |
| mem_wdata | input | 36 | Host memory write data |
| mem_rdata | output | 36 | Memory word at mem_idx |
| xfer_start | input | 1 | Starts a transfer when the engine is idle |
| xfer_word | input | 1 | 1 = 16-bit units, 0 = byte units |
| xfer_to_mem | input | 1 | 1 = device to memory, 0 = memory to device |
| xfer_addr | input | 18 | Starting bus byte address |
| xfer_count | input | 18 | Byte count |
| dev_wdata | input | 16 | Device data for the unit being handled |
| dev_rdata | output | 16 | Data extracted from memory |
| dev_rvalid | output | 1 | dev_rdata holds a newly read unit |
| cur_addr | output | 18 | Bus address of the unit handled next |
| xfer_busy | output | 1 | Engine is running |
| xfer_done | output | 1 | One-cycle end-of-transfer pulse |
| xfer_residual | output | 18 | Bytes not moved, valid with xfer_done |
| adapter_timeout | output | 1 | Sticky translation or nonexistent-memory fault flag |

## Verification
Map and host memory reads are combinational, so they are sampled in the cycle their index is driven, and a map write shows up one edge later. After the start edge, each unit takes one edge. Its read data is due after that edge, and the done pulse with the residual is due one edge after the last unit, or on the first engine edge for a zero count or an immediate fault. The bench drives stimulus and samples results on falling edges. It steps its own address, count and memory model one edge at a time, so each result is compared in exactly the cycle it becomes due. Memory is swept word by word after every transfer.

// File: rtl/dma_lane_pkg.sv
package dma_lane_pkg;
  localparam int BUS_AW        = 18;
  localparam int WORD_W        = 36;
  localparam int HALF_W        = 16;
  localparam int MAP_VALID_BIT = 15;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_e;

  // bit position of a byte lane inside a memory word
  function automatic logic [5:0] byte_shift(input logic [1:0] lane);
    case (lane)
      2'd0:    return 6'd18;
      2'd1:    return 6'd26;
      2'd2:    return 6'd0;
      default: return 6'd8;
    endcase
  endfunction

  // bit position of a 16-bit unit: low half for address bit 1 set
  function automatic logic [5:0] half_shift(input logic sel_low);
    return sel_low ? 6'd0 : 6'd18;
  endfunction
endpackage

// File: rtl/dma_page_map.sv
module dma_page_map
  import dma_lane_pkg::*;
#(
  parameter int MAP_DEPTH = 64,
  parameter int OFF_W     = 9,
  parameter int PA_W      = 12,
  parameter int MAP_IW    = $clog2(MAP_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAP_IW-1:0] host_idx,
  input  logic              host_we,
  input  logic [17:0]       host_wdata,
  output logic [17:0]       host_rdata,
  input  logic [17:0]       xl_addr,
  output logic              xl_ok,
  output logic [PA_W-1:0]   xl_pa
);
  localparam int PPN_W = PA_W - OFF_W;
  localparam int VPN_W = 16 - OFF_W;
  localparam logic [VPN_W:0]  PAGE_LIM = (VPN_W + 1)'(MAP_DEPTH);
  localparam logic [MAP_IW:0] IDX_LIM  = (MAP_IW + 1)'(MAP_DEPTH);

  logic [MAP_DEPTH-1:0] valid_q;
  logic [PPN_W-1:0]     ppn_q [MAP_DEPTH];
  logic [MAP_DEPTH-1:0] wr_hit;
  logic                 idx_in;

  assign idx_in = {1'b0, host_idx} < IDX_LIM;

  for (genvar e = 0; e < MAP_DEPTH; e++) begin : g_hit
    assign wr_hit[e] = host_we && (host_idx == MAP_IW'(e));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < MAP_DEPTH; e++) begin
        valid_q[e] <= 1'b0;
        ppn_q[e]   <= '0;
      end
    end else begin
      for (int e = 0; e < MAP_DEPTH; e++) begin
        if (wr_hit[e]) begin
          valid_q[e] <= host_wdata[MAP_VALID_BIT];
          ppn_q[e]   <= host_wdata[PPN_W-1:0];
        end
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    if (idx_in) begin
      host_rdata[MAP_VALID_BIT] = valid_q[host_idx];
      host_rdata[PPN_W-1:0]     = ppn_q[host_idx];
    end
  end

  // translation of the engine's current bus address
  logic [15:0]       widx;
  logic [VPN_W-1:0]  vpn;
  logic [OFF_W-1:0]  off;
  logic [MAP_IW-1:0] sel;
  logic              page_in;

  assign widx    = xl_addr[17:2];
  assign vpn     = widx[15:OFF_W];
  assign off     = widx[OFF_W-1:0];
  assign sel     = vpn[MAP_IW-1:0];
  assign page_in = {1'b0, vpn} < PAGE_LIM;
  assign xl_ok   = page_in && !xl_addr[17] && valid_q[sel];
  assign xl_pa   = {ppn_q[sel], off};

  logic unused_bits;
  assign unused_bits = ^{host_wdata[17:16], host_wdata[14:PPN_W], xl_addr[1:0]};

  assert_map_writeback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && idx_in) |=>
      ((host_idx != $past(host_idx)) ||
       (host_rdata[MAP_VALID_BIT] == $past(host_wdata[MAP_VALID_BIT]))));
endmodule

// File: rtl/dma_word_store.sv
module dma_word_store
  import dma_lane_pkg::*;
#(
  parameter int WORDS = 1024,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic [AW-1:0]     host_idx,
  input  logic              host_we,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic [AW-1:0]     eng_idx,
  input  logic              eng_we,
  input  logic [WORD_W-1:0] eng_wdata,
  output logic [WORD_W-1:0] eng_rdata
);
  localparam logic [AW:0] LIM = (AW + 1)'(WORDS);

  logic [WORD_W-1:0] mem_q [WORDS];
  logic              host_in;
  logic              eng_in;

  assign host_in = {1'b0, host_idx} < LIM;
  assign eng_in  = {1'b0, eng_idx} < LIM;

  always_ff @(posedge clk) begin
    if (eng_we && eng_in) begin
      mem_q[eng_idx] <= eng_wdata;
    end else if (host_we && host_in) begin
      mem_q[host_idx] <= host_wdata;
    end
  end

  assign host_rdata = host_in ? mem_q[host_idx] : '0;
  assign eng_rdata  = eng_in  ? mem_q[eng_idx]  : '0;
endmodule

// File: rtl/dma_lane_engine.sv
module dma_lane_engine
  import dma_lane_pkg::*;
#(
  parameter int PA_W      = 12,
  parameter int MEM_WORDS = 1024,
  parameter int MEM_AW    = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              word_mode,
  input  logic              to_mem,
  input  logic [17:0]       start_addr,
  input  logic [17:0]       count,
  input  logic [15:0]       wdata,
  input  logic              xl_ok,
  input  logic [PA_W-1:0]   xl_pa,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [MEM_AW-1:0] mem_idx,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [17:0]       cur_addr,
  output logic              busy,
  output logic              done,
  output logic [17:0]       residual,
  output logic [15:0]       rdata,
  output logic              rvalid,
  output logic              timeout
);
  localparam logic [PA_W:0] MEM_LIM = (PA_W + 1)'(MEM_WORDS);

  eng_state_e  state_q, state_d;
  logic [17:0] cur_q, cur_d, rem_q, rem_d, res_q, res_d;
  logic        word_q, tomem_q, done_q, done_d, rvalid_q, rvalid_d, tmo_q, tmo_d;
  logic [15:0] rdata_q, rdata_d;
  logic        pos_en, mode_en;

  logic        is_run, nxm, unit, fault, finish;
  logic [5:0]  sh;
  logic [WORD_W-1:0] field, ins, ext;
  logic [17:0] step;

  assign is_run = (state_q == ENG_RUN);
  assign nxm    = {1'b0, xl_pa} >= MEM_LIM;
  assign unit   = is_run && (rem_q != '0) && xl_ok && !nxm;
  assign fault  = is_run && (rem_q != '0) && (!xl_ok || nxm);
  assign finish = is_run && ((rem_q == '0) || !xl_ok || nxm);
  assign step   = word_q ? 18'd2 : 18'd1;

  // lane placement
  assign sh        = word_q ? half_shift(cur_q[1]) : byte_shift(cur_q[1:0]);
  assign field     = (word_q ? 36'hFFFF : 36'hFF) << sh;
  assign ins       = (word_q ? {20'b0, wdata} : {28'b0, wdata[7:0]}) << sh;
  assign mem_wdata = (mem_rdata & ~field) | ins;
  assign ext       = (mem_rdata & field) >> sh;
  assign mem_we    = unit && tomem_q;
  assign mem_idx   = xl_pa[MEM_AW-1:0];

  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    rem_d    = rem_q;
    pos_en   = 1'b0;
    mode_en  = 1'b0;
    if (!is_run && start) begin
      state_d = ENG_RUN;
      cur_d   = word_mode ? {start_addr[17:1], 1'b0} : start_addr;
      rem_d   = word_mode ? {count[17:1], 1'b0} : count;
      pos_en  = 1'b1;
      mode_en = 1'b1;
    end else if (unit) begin
      cur_d  = cur_q + step;
      rem_d  = rem_q - step;
      pos_en = 1'b1;
    end else if (finish) begin
      state_d = ENG_IDLE;
    end
    done_d   = finish;
    res_d    = finish ? rem_q : res_q;
    rvalid_d = unit && !tomem_q;
    rdata_d  = rvalid_d ? ext[15:0] : rdata_q;
    tmo_d    = tmo_q | fault;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ENG_IDLE;
      cur_q    <= '0;
      rem_q    <= '0;
      word_q   <= 1'b0;
      tomem_q  <= 1'b0;
      done_q   <= 1'b0;
      res_q    <= '0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      tmo_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      done_q   <= done_d;
      res_q    <= res_d;
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
      tmo_q    <= tmo_d;
      if (pos_en) begin
        cur_q <= cur_d;
        rem_q <= rem_d;
      end
      if (mode_en) begin
        word_q  <= word_mode;
        tomem_q <= to_mem;
      end
    end
  end

  assign cur_addr = cur_q;
  assign busy     = is_run;
  assign done     = done_q;
  assign residual = res_q;
  assign rdata    = rdata_q;
  assign rvalid   = rvalid_q;
  assign timeout  = tmo_q;

  logic unused_ext;
  assign unused_ext = ^ext[WORD_W-1:16];

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_no_write_on_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (xl_ok && !nxm));
  assert_timeout_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> (done && residual != '0));
  assert_timeout_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> timeout);
  assert_word_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && word_q) |-> (!cur_q[0] && !rem_q[0]));
endmodule

// File: rtl/dma_lane_mapper.sv
module dma_lane_mapper
  import dma_lane_pkg::*;
#(
  parameter  int MAP_DEPTH = 64,
  parameter  int OFF_W     = 9,
  parameter  int PA_W      = 12,
  parameter  int MEM_WORDS = 1024,
  localparam int MAP_IW    = $clog2(MAP_DEPTH),
  localparam int MEM_AW    = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAP_IW-1:0] map_idx,
  input  logic              map_we,
  input  logic [17:0]       map_wdata,
  output logic [17:0]       map_rdata,
  input  logic [MEM_AW-1:0] mem_idx,
  input  logic              mem_we,
  input  logic [35:0]       mem_wdata,
  output logic [35:0]       mem_rdata,
  input  logic              xfer_start,
  input  logic              xfer_word,
  input  logic              xfer_to_mem,
  input  logic [17:0]       xfer_addr,
  input  logic [17:0]       xfer_count,
  input  logic [15:0]       dev_wdata,
  output logic [15:0]       dev_rdata,
  output logic              dev_rvalid,
  output logic [17:0]       cur_addr,
  output logic              xfer_busy,
  output logic              xfer_done,
  output logic [17:0]       xfer_residual,
  output logic              adapter_timeout
);
  logic              xl_ok;
  logic [PA_W-1:0]   xl_pa;
  logic [MEM_AW-1:0] eng_idx;
  logic              eng_we;
  logic [35:0]       eng_wdata, eng_rdata;

  dma_page_map #(
    .MAP_DEPTH(MAP_DEPTH), .OFF_W(OFF_W), .PA_W(PA_W), .MAP_IW(MAP_IW)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .host_idx(map_idx), .host_we(map_we), .host_wdata(map_wdata),
    .host_rdata(map_rdata),
    .xl_addr(cur_addr), .xl_ok(xl_ok), .xl_pa(xl_pa)
  );

  dma_word_store #(
    .WORDS(MEM_WORDS), .AW(MEM_AW)
  ) u_store (
    .clk(clk),
    .host_idx(mem_idx), .host_we(mem_we), .host_wdata(mem_wdata),
    .host_rdata(mem_rdata),
    .eng_idx(eng_idx), .eng_we(eng_we), .eng_wdata(eng_wdata),
    .eng_rdata(eng_rdata)
  );

  dma_lane_engine #(
    .PA_W(PA_W), .MEM_WORDS(MEM_WORDS), .MEM_AW(MEM_AW)
  ) u_eng (
    .clk(clk), .rst_n(rst_n),
    .start(xfer_start), .word_mode(xfer_word), .to_mem(xfer_to_mem),
    .start_addr(xfer_addr), .count(xfer_count), .wdata(dev_wdata),
    .xl_ok(xl_ok), .xl_pa(xl_pa), .mem_rdata(eng_rdata),
    .mem_idx(eng_idx), .mem_we(eng_we), .mem_wdata(eng_wdata),
    .cur_addr(cur_addr), .busy(xfer_busy), .done(xfer_done),
    .residual(xfer_residual), .rdata(dev_rdata), .rvalid(dev_rvalid),
    .timeout(adapter_timeout)
  );
endmodule

// File: tb/tb_dma_lane_mapper.sv
module tb_dma_lane_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int MAP_DEPTH  = 8;
  localparam int OFF_W      = 2;
  localparam int PA_W       = 6;
  localparam int MEM_WORDS  = 48;
  localparam int MAP_IW     = $clog2(MAP_DEPTH);
  localparam int MEM_AW     = $clog2(MEM_WORDS);

  logic clk = 1'b0;
  logic rst_n;
  logic [MAP_IW-1:0] map_idx;
  logic map_we;
  logic [17:0] map_wdata, map_rdata;
  logic [MEM_AW-1:0] mem_idx;
  logic mem_we;
  logic [35:0] mem_wdata, mem_rdata;
  logic xfer_start, xfer_word, xfer_to_mem;
  logic [17:0] xfer_addr, xfer_count;
  logic [15:0] dev_wdata, dev_rdata;
  logic dev_rvalid, xfer_busy, xfer_done, adapter_timeout;
  logic [17:0] cur_addr, xfer_residual;

  int checks = 0;
  int fails  = 0;

  logic [35:0] mdl_mem [MEM_WORDS];
  bit          mdl_valid [MAP_DEPTH];
  int          mdl_ppn [MAP_DEPTH];
  bit          mdl_tmo;

  dma_lane_mapper #(
    .MAP_DEPTH(MAP_DEPTH), .OFF_W(OFF_W), .PA_W(PA_W), .MEM_WORDS(MEM_WORDS)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .map_idx(map_idx), .map_we(map_we), .map_wdata(map_wdata), .map_rdata(map_rdata),
    .mem_idx(mem_idx), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .xfer_start(xfer_start), .xfer_word(xfer_word), .xfer_to_mem(xfer_to_mem),
    .xfer_addr(xfer_addr), .xfer_count(xfer_count),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_rvalid(dev_rvalid),
    .cur_addr(cur_addr), .xfer_busy(xfer_busy), .xfer_done(xfer_done),
    .xfer_residual(xfer_residual), .adapter_timeout(adapter_timeout)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input logic [17:0] a, input logic [15:0] s);
    return a[15:0] * 16'h003b + s;
  endfunction

  // model translation: 16-byte pages (4 words), 8 map entries, 48 words
  task automatic xlate(input logic [17:0] a, output bit ok, output int pa);
    int vpn;
    vpn = int'(a[17:4]);
    pa  = 0;
    ok  = 1'b0;
    if (!a[17] && vpn < MAP_DEPTH && mdl_valid[vpn]) begin
      pa = mdl_ppn[vpn] * 4 + int'(a[3:2]);
      ok = (pa < MEM_WORDS);
    end
  endtask

  function automatic logic [15:0] m_get(input logic [35:0] w, input bit wd,
                                        input logic [1:0] lo);
    if (wd) return lo[1] ? w[15:0] : w[33:18];
    case (lo)
      2'd0: return {8'h00, w[25:18]};
      2'd1: return {8'h00, w[33:26]};
      2'd2: return {8'h00, w[7:0]};
      default: return {8'h00, w[15:8]};
    endcase
  endfunction

  function automatic logic [35:0] m_put(input logic [35:0] w, input bit wd,
                                        input logic [1:0] lo, input logic [15:0] d);
    logic [35:0] r;
    r = w;
    if (wd) begin
      if (lo[1]) r[15:0] = d;
      else       r[33:18] = d;
    end else begin
      case (lo)
        2'd0: r[25:18] = d[7:0];
        2'd1: r[33:26] = d[7:0];
        2'd2: r[7:0]   = d[7:0];
        default: r[15:8] = d[7:0];
      endcase
    end
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mdl_tmo = 1'b0;
    for (int e = 0; e < MAP_DEPTH; e++) mdl_valid[e] = 1'b0;
    // R11: reset state and cleared map
    check(!xfer_busy && !xfer_done && !dev_rvalid && !adapter_timeout, "R11",
          "idle outputs after reset",
          {xfer_busy, xfer_done, dev_rvalid, adapter_timeout}, 0);
    for (int e = 0; e < MAP_DEPTH; e++) begin
      map_idx = MAP_IW'(e);
      #1;
      check(map_rdata == 18'h0, "R11", "map entry cleared", map_rdata, 0);
    end
  endtask

  task automatic program_map();
    logic [17:0] d, e_rd;
    for (int e = 0; e < MAP_DEPTH; e++) begin
      mdl_valid[e] = (e != 5);
      mdl_ppn[e]   = (e * 5 + 3) % 16;
      d = 18'h24070 | 18'(mdl_ppn[e]) | (mdl_valid[e] ? 18'h08000 : 18'h0);
      @(negedge clk);
      map_idx = MAP_IW'(e); map_wdata = d; map_we = 1'b1;
      @(negedge clk);
      map_we = 1'b0;
      #1;
      e_rd = 18'(mdl_ppn[e]) | (mdl_valid[e] ? 18'h08000 : 18'h0);
      // R2: fields kept, all other bits read as zero
      check(map_rdata == e_rd, "R2", "map readback", map_rdata, e_rd);
    end
  endtask

  task automatic check_mem(input string req);
    for (int i = 0; i < MEM_WORDS; i++) begin
      mem_idx = MEM_AW'(i);
      #1;
      check(mem_rdata == mdl_mem[i], req, $sformatf("memory word %0d", i),
            mem_rdata, mdl_mem[i]);
    end
  endtask

  task automatic run_xfer(input bit wd, input bit tm, input logic [17:0] a,
                          input logic [17:0] c, input logic [15:0] seed,
                          input logic [17:0] exp_res, input string req);
    logic [17:0] m_cur, m_rem, step;
    bit ok, ended;
    int pa;
    logic [15:0] d;
    @(negedge clk);
    xfer_word = wd; xfer_to_mem = tm; xfer_addr = a; xfer_count = c;
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    check(xfer_busy == 1'b1, "R10", "busy after start edge", xfer_busy, 1);
    m_cur = wd ? {a[17:1], 1'b0} : a;
    m_rem = wd ? {c[17:1], 1'b0} : c;
    step  = wd ? 18'd2 : 18'd1;
    ended = 1'b0;
    for (int g = 0; g < 300 && !ended; g++) begin
      ok = 1'b0;
      pa = 0;
      if (m_rem != 0) xlate(m_cur, ok, pa);
      d = pat(m_cur, seed);
      dev_wdata = d;
      @(negedge clk);
      if (ok) begin
        check(!xfer_done, "R10", "no done while units remain", xfer_done, 0);
        if (tm) begin
          mdl_mem[pa] = m_put(mdl_mem[pa], wd, m_cur[1:0], d);
        end else begin
          check(dev_rvalid && dev_rdata == m_get(mdl_mem[pa], wd, m_cur[1:0]),
                wd ? "R6 R1" : "R4 R1", "read unit data",
                {dev_rvalid, dev_rdata}, {1'b1, m_get(mdl_mem[pa], wd, m_cur[1:0])});
        end
        m_cur = m_cur + step;
        m_rem = m_rem - step;
      end else begin
        if (m_rem != 0) mdl_tmo = 1'b1;
        check(xfer_done && !xfer_busy, "R10", "done pulse at end",
              {xfer_done, xfer_busy}, 2'b10);
        check(xfer_residual == exp_res && m_rem == exp_res, req, "residual",
              xfer_residual, exp_res);
        check(adapter_timeout == mdl_tmo, "R8", "timeout flag",
              adapter_timeout, mdl_tmo);
        ended = 1'b1;
      end
    end
    if (!ended) check(1'b0, req, "transfer never ended", 0, 1);
    @(negedge clk);
    check(!xfer_done, "R10", "done lasts one cycle", xfer_done, 0);
    check_mem(tm ? (wd ? "R7" : "R5") : "R12");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b1; map_idx = '0; map_we = 1'b0; map_wdata = '0;
    mem_idx = '0; mem_we = 1'b0; mem_wdata = '0;
    xfer_start = 1'b0; xfer_word = 1'b0; xfer_to_mem = 1'b0;
    xfer_addr = '0; xfer_count = '0; dev_wdata = '0;
    mdl_tmo = 1'b0;
    do_reset();

    for (int i = 0; i < MEM_WORDS; i++) begin
      mdl_mem[i] = 36'hA5A5_A5A5A ^ (36'(i) * 36'h0_1020_3051);
      @(negedge clk);
      mem_idx = MEM_AW'(i); mem_wdata = mdl_mem[i]; mem_we = 1'b1;
    end
    @(negedge clk);
    mem_we = 1'b0;
    check_mem("R1");

    program_map();

    // R5 R9: byte writes over two whole pages
    run_xfer(1'b0, 1'b1, 18'h00030, 18'd32, 16'h1111, 18'd0, "R9");
    // R4 R9: byte reads from an odd start across a page boundary
    run_xfer(1'b0, 1'b0, 18'h00031, 18'd20, 16'h0000, 18'd0, "R9");
    // R6 R7: word writes, odd start and count forced even
    run_xfer(1'b1, 1'b1, 18'h00063, 18'd21, 16'h7a7a, 18'd0, "R6");
    // R6: word reads over two pages
    run_xfer(1'b1, 1'b0, 18'h00000, 18'd32, 16'h0000, 18'd0, "R9");
    // R9: zero count
    run_xfer(1'b0, 1'b1, 18'h00010, 18'd0, 16'h2222, 18'd0, "R9");
    // R3 R8: invalid entry on the first unit
    run_xfer(1'b0, 1'b1, 18'h00058, 18'd16, 16'h3333, 18'd16, "R3");

    do_reset();
    program_map();
    // R8: nonexistent memory after four good word reads
    run_xfer(1'b1, 1'b0, 18'h00018, 18'd20, 16'h0000, 18'd12, "R8");

    do_reset();
    program_map();
    // R3: page number beyond the map after two bytes
    run_xfer(1'b0, 1'b1, 18'h0007E, 18'd4, 16'h4444, 18'd2, "R3");
    // R3: address bit 17 set
    run_xfer(1'b0, 1'b1, 18'h20010, 18'd3, 16'h5555, 18'd3, "R3");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule